// File: doc/BRIEF.md
# Outbound Message Post Queue Controller

This block runs the bookkeeping for a circular queue of message frame addresses that sits in local memory. The local processor adds an entry by first storing a frame address in memory at the current head slot. It then writes the advanced head pointer into the block. An external bus master removes entries one at a time by reading a queue port register. For each such read, the block fetches the word at the tail slot over a simple local-memory read interface, returns it as the read data and then steps the tail pointer forward.

The block keeps a "queue not empty" status bit that follows the pointer comparison. It also drives an interrupt output, which a mask bit can suppress. Both pointers are byte addresses inside a power-of-two region that starts at `BASE`. They step by 4 and wrap at the end of the region. The status, mask and port registers sit on the external-master port only. The local port can only write the head pointer.

External-master transfer: the master raises `xm_req` together with `xm_sel`, `xm_we` and `xm_wdata`, and holds them until it sees `xm_ready` high. The transfer completes in that cycle, and the master drops `xm_req` before the next edge. Register select codes are: 0 status, 1 mask, 2 queue port, 3 reserved.

Top module: `post_queue_ctrl`

## Requirements
- R1: After reset, `head_ptr` and `tail_ptr` both equal `BASE`, the mask bit is 1, `irq_o` is 0, and `mem_req` and `xm_ready` are 0.
- R2: A local write (`lp_head_we`) loads the head pointer on the next cycle with `BASE + 4*lp_head_wdata[IDXW+1:2]`, and all other data bits are ignored. The head pointer changes only on such a write.
- R3: The status register (select 0) reads bit 0 as 1 when the pointers differ and as 0 when they are equal. Bit 0 follows a pointer change one cycle later, and bits 31:1 read 0.
- R4: `irq_o` is 1 exactly when the status bit is 1 and the mask bit is 0. A set mask bit forces `irq_o` low but does not change the status bit.
- R5: A port read (select 2, `xm_we`=0) on a non-empty queue raises `mem_req` with `mem_addr` equal to the tail pointer. It completes with `xm_rdata` equal to the returned `mem_rdata`, and the tail pointer then advances by 4.
- R6: A port read on an empty queue returns 0xFFFF_FFFF, raises no `mem_req` and leaves the tail pointer unchanged.
- R7: Writing any value to the status register leaves the status bit unchanged, because the bit is read-only.
- R8: A mask write (select 1) loads the mask bit from `xm_wdata[0]`. A mask read returns it in bit 0, with the other bits 0.
- R9: The tail pointer advances from `BASE + 4*(DEPTH-1)` back to `BASE`.
- R10: Only one fetch is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until `mem_valid`, and `xm_ready` stays low until then.
- R11: When a head write and a tail advance land in the same cycle, both pointers take their new values.
- R12: Writes to the port register and any access to select 3 change neither pointer nor the mask, and a select-3 read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_head_we | input | 1 | Local head pointer write strobe |
| lp_head_wdata | input | AW | New head pointer byte address |
| head_ptr | output | AW | Current head pointer |
| tail_ptr | output | AW | Current tail pointer |
| xm_req | input | 1 | External-master transfer request |
| xm_we | input | 1 | 1 = write, 0 = read |
| xm_sel | input | 2 | Register select: 0 status, 1 mask, 2 port, 3 reserved |
| xm_wdata | input | DW | Write data |
| xm_ready | output | 1 | Transfer completes this cycle |
| xm_rdata | output | DW | Read data, valid with xm_ready |
| mem_req | output | 1 | Local memory read request |
| mem_addr | output | AW | Local memory read address |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | DW | Returned memory word |
| irq_o | output | 1 | Active-high interrupt output |

## Verification
The post/remove path is driven by a seeded random mix of posts, port reads, mask writes and status writes. Each post writes a head value with random bits above and below the index field, which separates correct field extraction from plain copying. Random memory latency of 0 to 2 cycles tests whether the response waits for returned data rather than a fixed delay. Directed cases cover the empty read, the wrap of the tail at the end of the region, and a head write that lands in the very cycle the tail advances. That last case tells a design that updates both pointers apart from one that drops one of the two updates.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PORT = 2'd2,
        SEL_RSVD = 2'd3
    } pq_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RESP  = 2'd2
    } pq_st_e;

    localparam int STAT_NE_BIT = 0;
    localparam int MASK_BIT    = 0;

endpackage

// File: rtl/pq_ptr_regs.sv
module pq_ptr_regs #(
    parameter int              AW   = 32,
    parameter int              IDXW = 4,
    parameter logic [AW-1:0]   BASE = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_we,
    input  logic [AW-1:0] head_wdata,
    input  logic          tail_adv,
    output logic [AW-1:0] head_addr,
    output logic [AW-1:0] tail_addr,
    output logic          not_empty
);

    localparam int PADW = AW - IDXW - 2;

    typedef struct packed {
        logic [IDXW-1:0] head;
        logic [IDXW-1:0] tail;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    // Only the index field of the written address is kept.
    logic unused_wbits;
    assign unused_wbits = ^{head_wdata[AW-1:IDXW+2], head_wdata[1:0]};

    always_comb begin
        ptr_d = ptr_q;
        if (head_we) begin
            ptr_d.head = head_wdata[IDXW+1:2];
        end
        if (tail_adv) begin
            ptr_d.tail = ptr_q.tail + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign head_addr = BASE | {{PADW{1'b0}}, ptr_q.head, 2'b00};
    assign tail_addr = BASE | {{PADW{1'b0}}, ptr_q.tail, 2'b00};
    assign not_empty = (ptr_q.head != ptr_q.tail);

    // R2: head only moves on a local write
    p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !head_we |=> $stable(head_addr));

    // R5: tail only moves when the port sequencer advances it
    p_tail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tail_adv |=> $stable(tail_addr));

endmodule

// File: rtl/pq_irq_regs.sv
module pq_irq_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic not_empty,
    input  logic mask_we,
    input  logic mask_wbit,
    output logic stat_bit,
    output logic mask_bit,
    output logic irq_o
);

    typedef struct packed {
        logic stat;
        logic mask;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.stat = not_empty;
        if (mask_we) begin
            irq_d.mask = mask_wbit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '{stat: 1'b0, mask: 1'b1};
        end else begin
            irq_q <= irq_d;
        end
    end

    assign stat_bit = irq_q.stat;
    assign mask_bit = irq_q.mask;
    assign irq_o    = irq_q.stat & ~irq_q.mask;

    // R4: a set mask keeps the output quiet
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |-> !irq_o);

    // R3: status follows the pointer comparison one cycle later
    p_stat_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        not_empty |=> stat_bit);

    p_stat_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |=> !stat_bit);

endmodule

// File: rtl/pq_port_fsm.sv
module pq_port_fsm
    import pq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xm_req,
    input  logic          xm_we,
    input  logic [1:0]    xm_sel,
    input  logic [DW-1:0] xm_wdata,
    output logic          xm_ready,
    output logic [DW-1:0] xm_rdata,
    input  logic          stat_bit,
    input  logic          mask_bit,
    input  logic          not_empty,
    input  logic [AW-1:0] tail_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          tail_adv,
    output logic          mask_we,
    output logic          mask_wbit
);

    localparam logic [DW-1:0] EMPTY_WORD = {DW{1'b1}};

    typedef struct packed {
        pq_st_e        st;
        logic [DW-1:0] rdata;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    pq_sel_e sel;

    logic unused_wbits;
    assign unused_wbits = ^xm_wdata[DW-1:1];

    assign sel = pq_sel_e'(xm_sel);

    always_comb begin
        fsm_d     = fsm_q;
        tail_adv  = 1'b0;
        mask_we   = 1'b0;
        mask_wbit = xm_wdata[MASK_BIT];
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (xm_req) begin
                    fsm_d.st    = ST_RESP;
                    fsm_d.rdata = '0;
                    unique case (sel)
                        SEL_STAT: begin
                            fsm_d.rdata[STAT_NE_BIT] = stat_bit;
                        end
                        SEL_MASK: begin
                            mask_we                 = xm_we;
                            fsm_d.rdata[MASK_BIT]   = mask_bit;
                        end
                        SEL_PORT: begin
                            if (!xm_we && not_empty) begin
                                fsm_d.st = ST_FETCH;
                            end else begin
                                fsm_d.rdata = EMPTY_WORD;
                            end
                        end
                        default: begin
                            fsm_d.rdata = '0;
                        end
                    endcase
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    fsm_d.rdata = mem_rdata;
                    fsm_d.st    = ST_RESP;
                    tail_adv    = 1'b1;
                end
            end
            ST_RESP: begin
                fsm_d.st = ST_IDLE;
            end
            default: begin
                fsm_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, rdata: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign xm_ready = (fsm_q.st == ST_RESP);
    assign xm_rdata = fsm_q.rdata;
    assign mem_req  = (fsm_q.st == ST_FETCH);
    assign mem_addr = tail_addr;

    // R10: request held with a steady address until data returns
    p_one_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_no_ready_in_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !xm_ready);

    // R5: returned word goes out as the read data
    p_fetch_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (xm_ready && xm_rdata == $past(mem_rdata)));

    // R6: an empty port read never touches memory
    p_empty_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE && xm_req && sel == SEL_PORT && !not_empty)
        |=> (!mem_req && xm_ready && xm_rdata == EMPTY_WORD));

endmodule

// File: rtl/post_queue_ctrl.sv
module post_queue_ctrl #(
    parameter int            AW    = 32,
    parameter int            DW    = 32,
    parameter int            DEPTH = 16,
    parameter logic [AW-1:0] BASE  = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lp_head_we,
    input  logic [AW-1:0] lp_head_wdata,
    output logic [AW-1:0] head_ptr,
    output logic [AW-1:0] tail_ptr,
    input  logic          xm_req,
    input  logic          xm_we,
    input  logic [1:0]    xm_sel,
    input  logic [DW-1:0] xm_wdata,
    output logic          xm_ready,
    output logic [DW-1:0] xm_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq_o
);

    localparam int            IDXW      = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST_ADDR = BASE + AW'((DEPTH - 1) * 4);

    logic not_empty;
    logic tail_adv;
    logic stat_bit;
    logic mask_bit;
    logic mask_we;
    logic mask_wbit;

    pq_ptr_regs #(
        .AW   (AW),
        .IDXW (IDXW),
        .BASE (BASE)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_we    (lp_head_we),
        .head_wdata (lp_head_wdata),
        .tail_adv   (tail_adv),
        .head_addr  (head_ptr),
        .tail_addr  (tail_ptr),
        .not_empty  (not_empty)
    );

    pq_irq_regs u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .not_empty (not_empty),
        .mask_we   (mask_we),
        .mask_wbit (mask_wbit),
        .stat_bit  (stat_bit),
        .mask_bit  (mask_bit),
        .irq_o     (irq_o)
    );

    pq_port_fsm #(
        .AW (AW),
        .DW (DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xm_req    (xm_req),
        .xm_we     (xm_we),
        .xm_sel    (xm_sel),
        .xm_wdata  (xm_wdata),
        .xm_ready  (xm_ready),
        .xm_rdata  (xm_rdata),
        .stat_bit  (stat_bit),
        .mask_bit  (mask_bit),
        .not_empty (not_empty),
        .tail_addr (tail_ptr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .tail_adv  (tail_adv),
        .mask_we   (mask_we),
        .mask_wbit (mask_wbit)
    );

    // R9: tail wraps back to the region start
    p_tail_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && tail_ptr == LAST_ADDR) |=> (tail_ptr == BASE));

    // R5: a completed fetch moves the tail by one entry
    p_tail_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && tail_ptr != LAST_ADDR) |=> (tail_ptr == $past(tail_ptr) + AW'(4)));

endmodule

// File: tb/sim_post_queue_ctrl.sv
module sim_post_queue_ctrl;

    localparam int          AW    = 32;
    localparam int          DW    = 32;
    localparam int          DEPTH = 16;
    localparam logic [31:0] BASE  = 32'h0001_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lp_head_we;
    logic [AW-1:0] lp_head_wdata;
    logic [AW-1:0] head_ptr, tail_ptr;
    logic          xm_req, xm_we;
    logic [1:0]    xm_sel;
    logic [DW-1:0] xm_wdata, xm_rdata;
    logic          xm_ready;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_valid;
    logic [DW-1:0] mem_rdata;
    logic          irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit auto_mem = 1;

    logic [31:0] bench_mem [DEPTH];
    int h_m = 0, t_m = 0;
    bit mask_m = 1;

    always #5 clk = ~clk;

    post_queue_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lp_head_we(lp_head_we), .lp_head_wdata(lp_head_wdata),
        .head_ptr(head_ptr), .tail_ptr(tail_ptr),
        .xm_req(xm_req), .xm_we(xm_we), .xm_sel(xm_sel), .xm_wdata(xm_wdata),
        .xm_ready(xm_ready), .xm_rdata(xm_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .irq_o(irq_o)
    );

    function automatic logic [31:0] slot_addr(input int idx);
        return BASE | (32'(idx) << 2);
    endfunction

    function automatic bit exp_irq();
        return (h_m != t_m) && !mask_m;
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory responder with 0..2 cycles of latency
    initial begin
        int lat = 0;
        mem_valid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (auto_mem) begin
                mem_valid = 1'b0;
                if (mem_req) begin
                    if (lat == 0) begin
                        mem_valid = 1'b1;
                        mem_rdata = bench_mem[(mem_addr - BASE) >> 2];
                        lat = int'($urandom % 3);
                    end else begin
                        lat--;
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=complete");
        finish_run();
    end

    task automatic xfer(input logic [1:0] sel, input bit we, input logic [31:0] wd,
                        output logic [31:0] rd, output int reqs);
        int guard = 0;
        reqs = 0;
        @(negedge clk);
        xm_req = 1'b1; xm_sel = sel; xm_we = we; xm_wdata = wd;
        do begin
            @(negedge clk);
            guard++;
            if (mem_req) begin
                reqs++;
                chk_eq("R10 mem_addr equals tail", mem_addr, slot_addr(t_m));
            end
        end while (!xm_ready && guard < 50);
        rd = xm_rdata;
        xm_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic lp_write(input logic [31:0] v);
        @(negedge clk);
        lp_head_we = 1'b1; lp_head_wdata = v;
        @(negedge clk);
        lp_head_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic post();
        int nh;
        logic [31:0] junk;
        nh = (h_m + 1) % DEPTH;
        if (nh == t_m) return;
        bench_mem[h_m] = $urandom;
        junk = $urandom;
        lp_write((junk & ~32'h3C) | (32'(nh) << 2));
        h_m = nh;
        chk_eq("R2 head from index field", head_ptr, slot_addr(h_m));
        chk_eq("R4 irq after post", {31'b0, irq_o}, {31'b0, exp_irq()});
    endtask

    task automatic pop();
        logic [31:0] rd;
        int reqs;
        int old_t;
        old_t = t_m;
        xfer(2'd2, 1'b0, 32'h0, rd, reqs);
        if (h_m == t_m) begin
            chk_eq("R6 empty read word", rd, 32'hFFFF_FFFF);
            chk_eq("R6 no memory request", 32'(reqs), 32'd0);
        end else begin
            chk_eq("R5 fetched word", rd, bench_mem[t_m]);
            t_m = (t_m + 1) % DEPTH;
            if (old_t == DEPTH - 1) begin
                chk_eq("R9 tail wrap", tail_ptr, BASE);
            end
        end
        chk_eq("R5 tail pointer", tail_ptr, slot_addr(t_m));
        chk_eq("R4 irq after pop", {31'b0, irq_o}, {31'b0, exp_irq()});
    endtask

    task automatic read_stat(input string tag);
        logic [31:0] rd;
        int reqs;
        xfer(2'd0, 1'b0, 32'h0, rd, reqs);
        chk_eq(tag, rd, {31'b0, (h_m != t_m)});
    endtask

    task automatic write_mask(input bit m);
        logic [31:0] rd;
        int reqs;
        xfer(2'd1, 1'b1, {$urandom, 1'b0} | {31'b0, m}, rd, reqs);
        mask_m = m;
        xfer(2'd1, 1'b0, 32'h0, rd, reqs);
        chk_eq("R8 mask readback", rd, {31'b0, m});
        chk_eq("R4 irq vs mask", {31'b0, irq_o}, {31'b0, exp_irq()});
    endtask

    initial begin
        logic [31:0] rd;
        int reqs;
        int nh;
        void'($urandom(32'd7331));
        rst_n = 1'b0;
        lp_head_we = 1'b0; lp_head_wdata = '0;
        xm_req = 1'b0; xm_we = 1'b0; xm_sel = '0; xm_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_eq("R1 head", head_ptr, BASE);
        chk_eq("R1 tail", tail_ptr, BASE);
        chk_eq("R1 irq", {31'b0, irq_o}, 32'd0);
        chk_eq("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk_eq("R1 xm_ready", {31'b0, xm_ready}, 32'd0);
        xfer(2'd1, 1'b0, 32'h0, rd, reqs);
        chk_eq("R1 mask set", rd, 32'd1);
        read_stat("R3 status empty at reset");

        // R6 empty port read
        pop();

        // R12 port write and reserved select
        xfer(2'd2, 1'b1, 32'h1234_5678, rd, reqs);
        chk_eq("R12 port write keeps tail", tail_ptr, BASE);
        chk_eq("R12 port write keeps head", head_ptr, BASE);
        chk_eq("R12 port write no fetch", 32'(reqs), 32'd0);
        xfer(2'd3, 1'b1, 32'hFFFF_FFFE, rd, reqs);
        xfer(2'd3, 1'b0, 32'h0, rd, reqs);
        chk_eq("R12 reserved reads zero", rd, 32'd0);
        xfer(2'd1, 1'b0, 32'h0, rd, reqs);
        chk_eq("R12 reserved write keeps mask", rd, 32'd1);

        // R3/R4 with one entry, masked then unmasked
        post();
        read_stat("R3 status set when pointers differ");
        chk_eq("R4 masked irq low", {31'b0, irq_o}, 32'd0);
        write_mask(1'b0);
        chk_eq("R4 unmasked irq high", {31'b0, irq_o}, 32'd1);
        write_mask(1'b1);
        read_stat("R4 mask keeps status");
        write_mask(1'b0);

        // R7 status write cannot clear the bit
        xfer(2'd0, 1'b1, 32'hFFFF_FFFF, rd, reqs);
        read_stat("R7 status unchanged by write");

        // R10/R11 directed: slow memory, head write in the tail-advance cycle
        post();
        auto_mem = 0;
        @(negedge clk);
        xm_req = 1'b1; xm_sel = 2'd2; xm_we = 1'b0;
        @(negedge clk);
        chk_eq("R10 request raised", {31'b0, mem_req}, 32'd1);
        chk_eq("R10 no ready while fetching", {31'b0, xm_ready}, 32'd0);
        chk_eq("R10 fetch address", mem_addr, slot_addr(t_m));
        @(negedge clk);
        chk_eq("R10 request held", {31'b0, mem_req}, 32'd1);
        chk_eq("R10 still not ready", {31'b0, xm_ready}, 32'd0);
        chk_eq("R10 address stable", mem_addr, slot_addr(t_m));
        nh = (h_m + 1) % DEPTH;
        bench_mem[h_m] = $urandom;
        mem_valid = 1'b1; mem_rdata = 32'hC0DE_5A11;
        lp_head_we = 1'b1; lp_head_wdata = slot_addr(nh);
        @(negedge clk);
        mem_valid = 1'b0; lp_head_we = 1'b0;
        chk_eq("R5 ready after data", {31'b0, xm_ready}, 32'd1);
        chk_eq("R5 directed data", xm_rdata, 32'hC0DE_5A11);
        h_m = nh;
        t_m = (t_m + 1) % DEPTH;
        chk_eq("R11 head updated", head_ptr, slot_addr(h_m));
        chk_eq("R11 tail updated", tail_ptr, slot_addr(t_m));
        xm_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        auto_mem = 1;

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 4) post();
            else if (op < 8) pop();
            else if (op == 8) write_mask(1'($urandom % 2));
            else begin
                xfer(2'd0, 1'b1, $urandom, rd, reqs);
                read_stat("R7 random status write");
            end
        end

        // drain to empty
        for (int i = 0; i < DEPTH; i++) begin
            if (h_m != t_m) pop();
        end
        read_stat("R3 status clear when drained");
        chk_eq("R3 irq low when drained", {31'b0, irq_o}, 32'd0);
        pop();

        finish_run();
    end

endmodule